// File: doc/BRIEF.md
# Hardware Breakpoint Unit for On-Chip Debug

This unit sits beside a CPU core and watches its instruction fetch, instruction retirement, data-memory strobes and change-of-flow signal. When one of the configured conditions matches, it raises a break request for the debug controller. A match on a program address raises `brk_pre`, which asks for a halt before the instruction runs. Data, masked, flow-change and single-step matches raise `brk_post`, which asks for a halt after the instruction has completed.

There are four address slots. Slot 0 is kept for single-step and is armed by a resume command that carries a step request. The three user slots are set up through a small register write port. Each user slot can be off, a program-address breakpoint, or a data breakpoint with its own access filter. User slots 2 and 3 can also be joined into one masked breakpoint, with slot 2 as the base and slot 3 as the mask. The masked breakpoint applies either to retired program addresses or to data accesses.

The write port checks every control word before it takes effect. A word that asks for more data breakpoints than the comparators allow is refused, and the previous setup stays in force. A status word records the causes of the most recent break, and the debugger clears it with a write.

Top module: `hwbrk_unit`

## Requirements
- R1: After reset, `brk_pre`, `brk_post`, `brk_status` and `cfg_err` are 0, and every user slot is off.
- R2: A user slot in program mode (mode code 01) asserts `brk_pre` for one cycle, on the clock edge after a cycle in which `fetch_valid` is high and `fetch_pc` equals the slot address. A retire at that same address does not raise any break.
- R3: A user slot in data mode (mode code 10) asserts `brk_post` on the clock edge after a cycle in which `dmem_addr` equals the slot address and the strobe is allowed by the slot's access code. The access codes are: 01 read only, 10 write only, 11 read or write. A data access never matches a slot that is in program mode.
- R4: Data and masked-data matching is suppressed for any address below 0x20, the register file. Address 0x20 is the lowest address that can match.
- R5: The control word (write address 0) has this layout:
  - bits [1:0], [3:2] and [5:4] hold the modes of slots 1, 2 and 3;
  - bit 6 enables the masked pair;
  - bit 7 selects the masked target, 0 for program and 1 for data;
  - bits [9:8], [11:10] and [13:12] hold the access codes of slots 1, 2 and 3;
  - bit 14 enables break on flow change.

  Slot addresses are written at addresses 1 to 3.
- R6: When the masked pair is enabled, slot 2 is the base and slot 3 is the mask, and their own modes are ignored. A match fires `brk_post` when (addr AND mask) equals (base AND mask).
  - In program target, addr is `retire_pc` on a retire.
  - In data target, addr is `dmem_addr`, filtered by the slot 2 access code.
  - An all-ones mask matches only the base, and an all-zeros mask matches every address.
- R7: A control word is rejected, with `cfg_err` set and the previous control kept, in two cases: all three modes are data, or the masked pair is enabled with two or more data modes. An accepted control write clears `cfg_err`.
- R8: With bit 14 set, a cycle with `retire_valid` and `retire_flow` both high gives `brk_post` on the next edge. `retire_flow` without `retire_valid` gives nothing.
- R9: A cycle with `resume` and `resume_step` both high arms single-step. The first later cycle with `retire_valid` gives one `brk_post`, and further retires give none. A `resume` without `resume_step` does not arm single-step.
- R10: `brk_status` changes on the same edge as a break output. It takes the set of causes of that cycle:
  - bit 0: step
  - bits 1 to 3: slots 1 to 3
  - bit 4: masked pair
  - bit 5: flow change

  It holds that value until the next break. A write to address 4 clears it, but a break in the same cycle wins over the clear.
- R11: The break outputs are one-cycle pulses, one for each triggering cycle. Consecutive triggering cycles give consecutive pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 3 | Configuration register select (0 control, 1-3 slot address, 4 status clear) |
| cfg_wdata | input | AW | Configuration write data |
| fetch_valid | input | 1 | Fetch program counter is valid |
| fetch_pc | input | AW | Address of the instruction about to execute |
| retire_valid | input | 1 | An instruction retired this cycle |
| retire_pc | input | AW | Address of the retired instruction |
| retire_flow | input | 1 | The retired instruction changed sequential flow |
| dmem_rd | input | 1 | Data memory read strobe |
| dmem_wr | input | 1 | Data memory write strobe |
| dmem_addr | input | AW | Data memory address |
| resume | input | 1 | Debugger resume command |
| resume_step | input | 1 | Resume is a single step |
| brk_pre | output | 1 | Break before execution |
| brk_post | output | 1 | Break after execution |
| brk_status | output | 6 | Causes of the most recent break |
| cfg_err | output | 1 | Last control write was rejected |

## Verification
A corrupted control word or a wrong slot address shows up on the edge right after the first fetch or access that should match. It appears either as a missing `brk_pre` or `brk_post` pulse, or as a pulse on the wrong output, because program and data matches drive different outputs. A single-step arm flag that is stuck or lost shows as either no break, or a repeated break, on the retires that follow a stepped resume. The status word exposes which comparator fired in the same cycle, so a cross-wired slot is told apart from a missing one at once. A refused configuration that leaks through becomes visible when an old breakpoint stops firing.

// File: rtl/hwbrk_pkg.sv
package hwbrk_pkg;

  localparam int NUM_USER = 3;
  localparam int CAUSE_W  = 6;

  localparam int C_STEP = 0;
  localparam int C_SLOT = 1;  // slots occupy C_SLOT .. C_SLOT+NUM_USER-1
  localparam int C_MASK = 4;
  localparam int C_FLOW = 5;

  localparam logic [1:0] MODE_OFF  = 2'b00;
  localparam logic [1:0] MODE_PROG = 2'b01;
  localparam logic [1:0] MODE_DATA = 2'b10;

  typedef struct packed {
    logic                          flow_en;
    logic [NUM_USER-1:0][1:0]      acc;
    logic                          mask_tgt_data;
    logic                          mask_en;
    logic [NUM_USER-1:0][1:0]      mode;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);

endpackage

// File: rtl/hwbrk_cfg.sv
module hwbrk_cfg
  import hwbrk_pkg::*;
#(
  parameter int AW = 16,
  parameter int CA = 3
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        cfg_we,
  input  logic [CA-1:0]               cfg_addr,
  input  logic [AW-1:0]               cfg_wdata,
  output ctrl_t                       ctrl,
  output logic [NUM_USER-1:0][AW-1:0] slot_addr,
  output logic                        cfg_err,
  output logic                        stat_clr
);

  localparam logic [CA-1:0] A_CTRL = '0;
  localparam logic [CA-1:0] A_CLR  = CA'(NUM_USER + 1);
  localparam int MAX_DATA = NUM_USER - 1;

  ctrl_t             new_ctrl;
  logic [NUM_USER-1:0] new_is_data;
  logic [NUM_USER-1:0] cur_is_data;
  logic              bad_word;
  logic              ctrl_wr;

  assign new_ctrl = ctrl_t'(cfg_wdata[CTRL_W-1:0]);

  for (genvar i = 0; i < NUM_USER; i++) begin : g_cnt
    assign new_is_data[i] = (new_ctrl.mode[i] == MODE_DATA);
    assign cur_is_data[i] = (ctrl.mode[i] == MODE_DATA);
  end

  always_comb begin
    int n;
    n = 0;
    for (int i = 0; i < NUM_USER; i++) n += int'(new_is_data[i]);
    bad_word = (n > MAX_DATA) || (new_ctrl.mask_en && (n > MAX_DATA - 1));
  end

  assign ctrl_wr  = cfg_we && (cfg_addr == A_CTRL);
  assign stat_clr = cfg_we && (cfg_addr == A_CLR);

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl    <= '0;
      cfg_err <= 1'b0;
    end else if (ctrl_wr) begin
      if (bad_word) begin
        cfg_err <= 1'b1;
      end else begin
        ctrl    <= new_ctrl;
        cfg_err <= 1'b0;
      end
    end
  end

  for (genvar i = 0; i < NUM_USER; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (rst)
        slot_addr[i] <= '0;
      else if (cfg_we && (cfg_addr == CA'(i + 1)))
        slot_addr[i] <= cfg_wdata;
    end
  end

  // R7
  cfg_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (ctrl_wr && bad_word) |=> ($stable(ctrl) && cfg_err));

  // R7
  data_cap_chk: assert property (@(posedge clk) disable iff (rst)
    $countones(cur_is_data) <= MAX_DATA);

endmodule

// File: rtl/hwbrk_cmp.sv
module hwbrk_cmp
  import hwbrk_pkg::*;
#(
  parameter int AW      = 16,
  parameter int RF_SIZE = 32
) (
  input  logic                        clk,
  input  logic                        rst,
  input  ctrl_t                       ctrl,
  input  logic [NUM_USER-1:0][AW-1:0] slot_addr,
  input  logic                        fetch_valid,
  input  logic [AW-1:0]               fetch_pc,
  input  logic                        retire_valid,
  input  logic [AW-1:0]               retire_pc,
  input  logic                        dmem_rd,
  input  logic                        dmem_wr,
  input  logic [AW-1:0]               dmem_addr,
  output logic [NUM_USER-1:0]         pre_hit,
  output logic [NUM_USER-1:0]         data_hit,
  output logic                        mask_hit
);

  localparam int BASE_IDX = NUM_USER - 2;
  localparam int MASK_IDX = NUM_USER - 1;

  logic data_ok;
  assign data_ok = (dmem_addr >= AW'(RF_SIZE));

  for (genvar i = 0; i < NUM_USER; i++) begin : g_cmp
    logic owned;
    logic acc_ok;
    if (i >= BASE_IDX) begin : g_pair
      assign owned = ctrl.mask_en;
    end else begin : g_solo
      assign owned = 1'b0;
    end
    assign acc_ok = (ctrl.acc[i][0] && dmem_rd) || (ctrl.acc[i][1] && dmem_wr);
    assign pre_hit[i]  = !owned && (ctrl.mode[i] == MODE_PROG) &&
                         fetch_valid && (fetch_pc == slot_addr[i]);
    assign data_hit[i] = !owned && (ctrl.mode[i] == MODE_DATA) &&
                         acc_ok && data_ok && (dmem_addr == slot_addr[i]);
  end

  logic [AW-1:0] m_base, m_mask, m_addr;
  logic          m_strobe;

  assign m_base = slot_addr[BASE_IDX];
  assign m_mask = slot_addr[MASK_IDX];
  assign m_addr = ctrl.mask_tgt_data ? dmem_addr : retire_pc;

  always_comb begin
    if (ctrl.mask_tgt_data)
      m_strobe = data_ok &&
                 ((ctrl.acc[BASE_IDX][0] && dmem_rd) || (ctrl.acc[BASE_IDX][1] && dmem_wr));
    else
      m_strobe = retire_valid;
  end

  assign mask_hit = ctrl.mask_en && m_strobe && ((m_addr & m_mask) == (m_base & m_mask));

  // R4
  rf_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    ((|data_hit) || (mask_hit && ctrl.mask_tgt_data)) |-> (dmem_addr >= AW'(RF_SIZE)));

endmodule

// File: rtl/hwbrk_step.sv
module hwbrk_step (
  input  logic clk,
  input  logic rst,
  input  logic resume,
  input  logic resume_step,
  input  logic retire_valid,
  output logic step_hit
);

  logic armed;

  assign step_hit = armed && retire_valid;

  always_ff @(posedge clk) begin
    if (rst)
      armed <= 1'b0;
    else if (resume)
      armed <= resume_step;
    else if (retire_valid)
      armed <= 1'b0;
  end

  // R9
  step_once_chk: assert property (@(posedge clk) disable iff (rst)
    (step_hit && !resume) |=> !step_hit);

endmodule

// File: rtl/hwbrk_unit.sv
module hwbrk_unit
  import hwbrk_pkg::*;
#(
  parameter int AW      = 16,
  parameter int RF_SIZE = 32,
  parameter int CA      = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cfg_we,
  input  logic [CA-1:0]      cfg_addr,
  input  logic [AW-1:0]      cfg_wdata,
  input  logic               fetch_valid,
  input  logic [AW-1:0]      fetch_pc,
  input  logic               retire_valid,
  input  logic [AW-1:0]      retire_pc,
  input  logic               retire_flow,
  input  logic               dmem_rd,
  input  logic               dmem_wr,
  input  logic [AW-1:0]      dmem_addr,
  input  logic               resume,
  input  logic               resume_step,
  output logic               brk_pre,
  output logic               brk_post,
  output logic [CAUSE_W-1:0] brk_status,
  output logic               cfg_err
);

  ctrl_t                       ctrl;
  logic [NUM_USER-1:0][AW-1:0] slot_addr;
  logic                        stat_clr;
  logic [NUM_USER-1:0]         pre_hit;
  logic [NUM_USER-1:0]         data_hit;
  logic                        mask_hit;
  logic                        step_hit;
  logic                        flow_hit;
  logic [CAUSE_W-1:0]          cause;
  logic                        pre_n, post_n;

  hwbrk_cfg #(.AW(AW), .CA(CA)) u_cfg (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .ctrl(ctrl), .slot_addr(slot_addr),
    .cfg_err(cfg_err), .stat_clr(stat_clr)
  );

  hwbrk_cmp #(.AW(AW), .RF_SIZE(RF_SIZE)) u_cmp (
    .clk(clk), .rst(rst), .ctrl(ctrl), .slot_addr(slot_addr),
    .fetch_valid(fetch_valid), .fetch_pc(fetch_pc),
    .retire_valid(retire_valid), .retire_pc(retire_pc),
    .dmem_rd(dmem_rd), .dmem_wr(dmem_wr), .dmem_addr(dmem_addr),
    .pre_hit(pre_hit), .data_hit(data_hit), .mask_hit(mask_hit)
  );

  hwbrk_step u_step (
    .clk(clk), .rst(rst), .resume(resume), .resume_step(resume_step),
    .retire_valid(retire_valid), .step_hit(step_hit)
  );

  assign flow_hit = ctrl.flow_en && retire_valid && retire_flow;

  always_comb begin
    cause = '0;
    cause[C_STEP] = step_hit;
    for (int i = 0; i < NUM_USER; i++)
      cause[C_SLOT + i] = pre_hit[i] || data_hit[i];
    cause[C_MASK] = mask_hit;
    cause[C_FLOW] = flow_hit;
  end

  assign pre_n  = |pre_hit;
  assign post_n = step_hit || (|data_hit) || mask_hit || flow_hit;

  always_ff @(posedge clk) begin
    if (rst) begin
      brk_pre    <= 1'b0;
      brk_post   <= 1'b0;
      brk_status <= '0;
    end else begin
      brk_pre  <= pre_n;
      brk_post <= post_n;
      if (|cause)
        brk_status <= cause;
      else if (stat_clr)
        brk_status <= '0;
    end
  end

  // R2
  pre_fetch_chk: assert property (@(posedge clk) disable iff (rst)
    brk_pre |-> $past(fetch_valid));

  // R11
  post_src_chk: assert property (@(posedge clk) disable iff (rst)
    brk_post |-> $past(retire_valid || dmem_rd || dmem_wr));

  // R10
  status_set_chk: assert property (@(posedge clk) disable iff (rst)
    (brk_pre || brk_post) |-> (brk_status != '0));

endmodule

// File: tb/test_hwbrk_unit.sv
module test_hwbrk_unit;

  localparam int AW = 16;
  localparam time CLK_P = 10ns;

  logic          clk = 1'b0;
  logic          rst;
  logic          cfg_we;
  logic [2:0]    cfg_addr;
  logic [AW-1:0] cfg_wdata;
  logic          fetch_valid;
  logic [AW-1:0] fetch_pc;
  logic          retire_valid;
  logic [AW-1:0] retire_pc;
  logic          retire_flow;
  logic          dmem_rd, dmem_wr;
  logic [AW-1:0] dmem_addr;
  logic          resume, resume_step;
  logic          brk_pre, brk_post, cfg_err;
  logic [5:0]    brk_status;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  always #(CLK_P/2) clk = ~clk;

  hwbrk_unit #(.AW(AW)) i_hwbrk_unit (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .fetch_valid(fetch_valid), .fetch_pc(fetch_pc), .retire_valid(retire_valid),
    .retire_pc(retire_pc), .retire_flow(retire_flow), .dmem_rd(dmem_rd),
    .dmem_wr(dmem_wr), .dmem_addr(dmem_addr), .resume(resume),
    .resume_step(resume_step), .brk_pre(brk_pre), .brk_post(brk_post),
    .brk_status(brk_status), .cfg_err(cfg_err)
  );

  typedef struct packed {
    logic        fv;
    logic [15:0] fpc;
    logic        rv;
    logic [15:0] rpc;
    logic        fl;
    logic        rd;
    logic        wr;
    logic [15:0] da;
    logic        ep;
    logic        eo;
    logic [5:0]  es;
  } vec_t;

  // control 0x7429: slot1 program, slot2 data read-only, slot3 data read/write, flow on
  localparam int NV = 13;
  localparam vec_t VEC [NV] = '{
    '{1'b1, 16'h0100, 1'b0, 16'h0000, 1'b0, 1'b0, 1'b0, 16'h0000, 1'b1, 1'b0, 6'h02},
    '{1'b1, 16'h0102, 1'b0, 16'h0000, 1'b0, 1'b0, 1'b0, 16'h0000, 1'b0, 1'b0, 6'h02},
    '{1'b0, 16'h0000, 1'b1, 16'h0100, 1'b0, 1'b0, 1'b0, 16'h0000, 1'b0, 1'b0, 6'h02},
    '{1'b0, 16'h0000, 1'b0, 16'h0000, 1'b0, 1'b1, 1'b0, 16'h0040, 1'b0, 1'b1, 6'h04},
    '{1'b0, 16'h0000, 1'b0, 16'h0000, 1'b0, 1'b0, 1'b1, 16'h0040, 1'b0, 1'b0, 6'h04},
    '{1'b0, 16'h0000, 1'b0, 16'h0000, 1'b0, 1'b1, 1'b0, 16'h0010, 1'b0, 1'b0, 6'h04},
    '{1'b0, 16'h0000, 1'b0, 16'h0000, 1'b0, 1'b0, 1'b1, 16'h0010, 1'b0, 1'b0, 6'h04},
    '{1'b0, 16'h0000, 1'b1, 16'h0200, 1'b1, 1'b0, 1'b0, 16'h0000, 1'b0, 1'b1, 6'h20},
    '{1'b0, 16'h0000, 1'b0, 16'h0000, 1'b1, 1'b0, 1'b0, 16'h0000, 1'b0, 1'b0, 6'h20},
    '{1'b1, 16'h0100, 1'b0, 16'h0000, 1'b0, 1'b1, 1'b0, 16'h0040, 1'b1, 1'b1, 6'h06},
    '{1'b0, 16'h0000, 1'b0, 16'h0000, 1'b0, 1'b0, 1'b0, 16'h0000, 1'b0, 1'b0, 6'h06},
    '{1'b0, 16'h0000, 1'b0, 16'h0000, 1'b0, 1'b1, 1'b0, 16'h0041, 1'b0, 1'b0, 6'h06},
    '{1'b0, 16'h0000, 1'b0, 16'h0000, 1'b0, 1'b1, 1'b0, 16'h0100, 1'b0, 1'b0, 6'h06}
  };

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle_inputs();
    fetch_valid = 0; fetch_pc = '0; retire_valid = 0; retire_pc = '0;
    retire_flow = 0; dmem_rd = 0; dmem_wr = 0; dmem_addr = '0;
    resume = 0; resume_step = 0; cfg_we = 0; cfg_addr = '0; cfg_wdata = '0;
  endtask

  task automatic cfg_write(input logic [2:0] a, input logic [15:0] d);
    cfg_we = 1; cfg_addr = a; cfg_wdata = d;
    @(posedge clk); #1;
    cfg_we = 0;
  endtask

  // apply one cycle of stimulus, sample just after the capturing edge
  task automatic step_cycle();
    @(posedge clk); #1;
  endtask

  task automatic data_cyc(input logic rd, input logic wr, input logic [15:0] a);
    dmem_rd = rd; dmem_wr = wr; dmem_addr = a;
    step_cycle();
    dmem_rd = 0; dmem_wr = 0;
  endtask

  task automatic retire_cyc(input logic [15:0] pc, input logic fl);
    retire_valid = 1; retire_pc = pc; retire_flow = fl;
    step_cycle();
    retire_valid = 0; retire_flow = 0;
  endtask

  initial begin
    #(CLK_P * 100000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    idle_inputs();
    rst = 1;
    repeat (3) @(posedge clk);
    #1; rst = 0;

    // R1 reset state
    chk("R1 brk_pre", 16'(brk_pre), 0);
    chk("R1 brk_post", 16'(brk_post), 0);
    chk("R1 status", 16'(brk_status), 0);
    chk("R1 cfg_err", 16'(cfg_err), 0);
    fetch_valid = 1; fetch_pc = 16'h0000; dmem_rd = 1; dmem_addr = 16'h0000;
    step_cycle();
    chk("R1 slots off pre", 16'(brk_pre), 0);
    chk("R1 slots off post", 16'(brk_post), 0);
    idle_inputs();

    // R5 setup
    cfg_write(3'd1, 16'h0100);
    cfg_write(3'd2, 16'h0040);
    cfg_write(3'd3, 16'h0010);
    cfg_write(3'd0, 16'h7429);
    chk("R7 accepted", 16'(cfg_err), 0);

    // R2 R3 R4 R8 R10 R11 table walk
    for (int i = 0; i < NV; i++) begin
      fetch_valid = VEC[i].fv; fetch_pc = VEC[i].fpc;
      retire_valid = VEC[i].rv; retire_pc = VEC[i].rpc; retire_flow = VEC[i].fl;
      dmem_rd = VEC[i].rd; dmem_wr = VEC[i].wr; dmem_addr = VEC[i].da;
      step_cycle();
      chk($sformatf("R2 vec%0d pre", i), 16'(brk_pre), 16'(VEC[i].ep));
      chk($sformatf("R3 vec%0d post", i), 16'(brk_post), 16'(VEC[i].eo));
      chk($sformatf("R10 vec%0d status", i), 16'(brk_status), 16'(VEC[i].es));
    end
    idle_inputs();

    // R11 consecutive pulses then quiet
    dmem_rd = 1; dmem_addr = 16'h0040;
    step_cycle();
    chk("R11 pulse1", 16'(brk_post), 1);
    step_cycle();
    chk("R11 pulse2", 16'(brk_post), 1);
    dmem_rd = 0;
    step_cycle();
    chk("R11 pulse end", 16'(brk_post), 0);

    // R4 boundary of register file
    cfg_write(3'd3, 16'h001F);
    data_cyc(0, 1, 16'h001F);
    chk("R4 0x1F suppressed", 16'(brk_post), 0);
    cfg_write(3'd3, 16'h0020);
    data_cyc(0, 1, 16'h0020);
    chk("R4 0x20 fires", 16'(brk_post), 1);
    chk("R4 slot3 status", 16'(brk_status), 16'h08);

    // R10 clear, and break beats clear
    cfg_write(3'd4, 16'h0000);
    chk("R10 cleared", 16'(brk_status), 0);
    cfg_we = 1; cfg_addr = 3'd4; dmem_rd = 1; dmem_addr = 16'h0040;
    step_cycle();
    idle_inputs();
    chk("R10 break wins", 16'(brk_status), 16'h04);

    // R7 rejects: three data; mask plus two data
    cfg_write(3'd0, 16'h002A);
    chk("R7 three data err", 16'(cfg_err), 1);
    fetch_valid = 1; fetch_pc = 16'h0100;
    step_cycle();
    idle_inputs();
    chk("R7 old config kept", 16'(brk_pre), 1);
    cfg_write(3'd0, 16'h004A);
    chk("R7 mask+2 data err", 16'(cfg_err), 1);
    data_cyc(1, 0, 16'h0040);
    chk("R7 old data slot kept", 16'(brk_post), 1);

    // R6 masked data: base 0x1230, mask 0xFFF0, access read/write
    cfg_write(3'd2, 16'h1230);
    cfg_write(3'd3, 16'hFFF0);
    cfg_write(3'd0, 16'h0CC0);
    chk("R7 accept clears err", 16'(cfg_err), 0);
    data_cyc(1, 0, 16'h1235);
    chk("R6 masked hit", 16'(brk_post), 1);
    chk("R6 masked status", 16'(brk_status), 16'h10);
    data_cyc(1, 0, 16'h1245);
    chk("R6 masked miss", 16'(brk_post), 0);
    cfg_write(3'd3, 16'hFFFF);
    data_cyc(0, 1, 16'h1230);
    chk("R6 all-ones base", 16'(brk_post), 1);
    data_cyc(0, 1, 16'h1231);
    chk("R6 all-ones other", 16'(brk_post), 0);
    cfg_write(3'd3, 16'h0000);
    data_cyc(1, 0, 16'h8000);
    chk("R6 all-zeros any", 16'(brk_post), 1);
    data_cyc(1, 0, 16'h0005);
    chk("R4 masked regfile", 16'(brk_post), 0);

    // R6 masked program target: mask 0xFF00
    cfg_write(3'd3, 16'hFF00);
    cfg_write(3'd0, 16'h0040);
    retire_cyc(16'h12AB, 0);
    chk("R6 masked retire", 16'(brk_post), 1);
    fetch_valid = 1; fetch_pc = 16'h12AB;
    step_cycle();
    idle_inputs();
    chk("R6 masked no pre", 16'(brk_pre), 0);
    retire_cyc(16'h13AB, 0);
    chk("R6 masked retire miss", 16'(brk_post), 0);

    // R8 flow disabled now
    retire_cyc(16'h0300, 1);
    chk("R8 flow off", 16'(brk_post), 0);

    // R9 single-step
    cfg_write(3'd0, 16'h0000);
    resume = 1; resume_step = 0;
    step_cycle();
    resume = 0;
    retire_cyc(16'h0400, 0);
    chk("R9 plain resume", 16'(brk_post), 0);
    resume = 1; resume_step = 1;
    step_cycle();
    resume = 0; resume_step = 0;
    chk("R9 no break on arm", 16'(brk_post), 0);
    step_cycle();
    chk("R9 wait idle", 16'(brk_post), 0);
    retire_cyc(16'h0402, 0);
    chk("R9 step break", 16'(brk_post), 1);
    chk("R9 step status", 16'(brk_status), 16'h01);
    retire_cyc(16'h0404, 0);
    chk("R9 only once", 16'(brk_post), 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule